// File: doc/BRIEF.md
# Squashed-Branch Replay Lookup

When a branch squash happens, the branch records of the younger branches are copied into a replay queue. This block answers the fetch-time questions asked of that queue. Each record in the queue holds a branch PC, an executed flag, a resolved direction and a loop-iteration tag. When the front end fetches a branch, it presents the PC. One cycle later the block reports whether a stored outcome applies to that fetch. On a hit it also reports the stored direction and whether the stored branch had executed.

The block keeps a replay head, which is an offset into the captured window. The head stays aligned with the dynamic loop iteration being fetched. If the head entry does not match, the block looks for the PC among entries that share the head's iteration tag:

- If no such entry holds the PC, the requested branch is an extra, control-dependent branch. The head does not move.
- If such an entry lies after the head, the entries in between were skipped. The head jumps to the matching entry.
- If such an entry lies before the head, the fetch has started a new iteration. The head moves to the next iteration and searches there.

Filling the queue and deciding whether to trust a returned outcome are handled elsewhere.

Top module: `rrl_replay_lookup`

## Requirements
- R1: After reset, no response is flagged valid, the head index is 0, and the captured window is empty, so any lookup misses.
- R2: A load sets the window start index and length and puts the head at the start. A lookup presented in the same cycle as a load is answered with a valid miss and does not move the head.
- R3: If the entry at the head holds the requested PC, the response is a hit carrying that entry's direction and executed flag, and the head advances by one.
- R4: Every lookup or load is answered with rsp_valid exactly one cycle later. Lookups may be presented on consecutive cycles, and each one sees the head left by the one before.
- R5: If no entry with the head's iteration tag holds the requested PC, the response is a miss and the head does not move.
- R6: If the first same-tag entry holding the PC lies after the head, the head moves to that entry, the response is a hit with that entry's data, and the head ends one past it.
- R7: If a same-tag entry holding the PC lies only before the head, the head moves to the first entry whose tag is later than the current tag. A match within that new iteration then gives a hit, and the head ends one past the match.
- R8: In the R7 case, if the new iteration holds no such PC, the response is a miss and the head stays at the first entry of the new iteration. If there is no later iteration, the head moves to the end of the window.
- R9: When same-tag matches exist both before and after the head, the match after the head is used.
- R10: Once the head reaches the end of the window, every lookup misses and the head holds until the next load.
- R11: Tags are TAG_W-bit serial numbers. Tag a is later than tag b when (a-b) mod 2^TAG_W is nonzero and below 2^(TAG_W-1), so 0 is later than 255 for TAG_W=8.
- R12: The window wraps around the queue. The entry at offset k sits at index (start+k) mod DEPTH, and head_idx_o reports the head that way. Entry i of each flat input occupies bits [i*W +: W], where W is that field's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new replay window |
| load_base_i | input | IDX_W | Queue index of the oldest window entry |
| load_len_i | input | OFF_W | Number of entries in the window (0..DEPTH) |
| q_pc_i | input | DEPTH*PC_W | Stored branch PCs |
| q_tag_i | input | DEPTH*TAG_W | Stored iteration tags |
| q_exec_i | input | DEPTH | Stored executed flags |
| q_dir_i | input | DEPTH | Stored directions (1 = taken) |
| req_valid_i | input | 1 | Fetch lookup request |
| req_pc_i | input | PC_W | PC of the fetched branch |
| rsp_valid_o | output | 1 | Response for the previous cycle's request or load |
| rsp_hit_o | output | 1 | Stored outcome applies |
| rsp_exec_o | output | 1 | Matched entry had executed |
| rsp_dir_o | output | 1 | Matched entry's direction |
| head_idx_o | output | IDX_W | Queue index of the current replay head |

## Verification
A window load and a fetch lookup can arrive in the same cycle, and the block must resolve that collision. The bench provokes it by asserting load_i and req_valid_i together, using a PC that would hit at the new head. It judges the outcome in two steps. First, the response must be a valid miss and the head must equal the new start index. Second, an immediate follow-up lookup of the same PC must hit and advance the head, which shows the colliding lookup left no trace.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
  typedef enum logic [2:0] {
    LK_EMPTY,
    LK_HIT_HEAD,
    LK_HIT_AHEAD,
    LK_HIT_NEXT,
    LK_MISS_NEXT,
    LK_MISS_END,
    LK_MISS_INSERT
  } lk_kind_e;
endpackage

// File: rtl/rrl_view.sv
module rrl_view #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]       base_i,
  input  logic [OFF_W-1:0]       len_i,
  input  logic [DEPTH*PC_W-1:0]  q_pc_i,
  input  logic [DEPTH*TAG_W-1:0] q_tag_i,
  input  logic [DEPTH-1:0]       q_exec_i,
  input  logic [DEPTH-1:0]       q_dir_i,
  input  logic [PC_W-1:0]        req_pc_i,
  output logic [DEPTH-1:0]       vld_o,
  output logic [DEPTH-1:0]       pc_eq_o,
  output logic [DEPTH*TAG_W-1:0] tag_o,
  output logic [DEPTH-1:0]       exec_o,
  output logic [DEPTH-1:0]       dir_o
);
  // Rotate the circular queue so that offset 0 is the window start.
  for (genvar o = 0; o < DEPTH; o++) begin : g_off
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] idx;
    assign sum = {1'b0, base_i} + (IDX_W+1)'(o);
    assign idx = (sum >= (IDX_W+1)'(DEPTH)) ? IDX_W'(sum - (IDX_W+1)'(DEPTH))
                                            : IDX_W'(sum);
    assign vld_o[o]   = OFF_W'(o) < len_i;
    assign pc_eq_o[o] = q_pc_i[idx*PC_W +: PC_W] == req_pc_i;
    assign tag_o[o*TAG_W +: TAG_W] = q_tag_i[idx*TAG_W +: TAG_W];
    assign exec_o[o]  = q_exec_i[idx];
    assign dir_o[o]   = q_dir_i[idx];
  end
endmodule

// File: rtl/rrl_first.sv
module rrl_first #(
  parameter int N = 16,
  parameter int W = 5
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] from_i,
  output logic         found_o,
  output logic [W-1:0] pos_o
);
  // Lowest set bit at or above from_i.
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i] && (W'(i) >= from_i)) begin
        found_o = 1'b1;
        pos_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/rrl_replay_lookup.sv
module rrl_replay_lookup
  import rrl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [IDX_W-1:0]       load_base_i,
  input  logic [OFF_W-1:0]       load_len_i,
  input  logic [DEPTH*PC_W-1:0]  q_pc_i,
  input  logic [DEPTH*TAG_W-1:0] q_tag_i,
  input  logic [DEPTH-1:0]       q_exec_i,
  input  logic [DEPTH-1:0]       q_dir_i,
  input  logic                   req_valid_i,
  input  logic [PC_W-1:0]        req_pc_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic                   rsp_exec_o,
  output logic                   rsp_dir_o,
  output logic [IDX_W-1:0]       head_idx_o
);
  function automatic logic ser_gt(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[TAG_W-1];
  endfunction

  logic [IDX_W-1:0] base_q, base_d;
  logic [OFF_W-1:0] len_q, len_d, hoff_q, hoff_d;
  logic             rsp_hit_d, rsp_exec_d, rsp_dir_d;
  logic             state_en;

  logic [DEPTH-1:0]       vld, pc_eq, r_exec, r_dir, tag_eq, tag_gt, nm_vec;
  logic [DEPTH*TAG_W-1:0] r_tag;

  rrl_view #(.DEPTH(DEPTH), .PC_W(PC_W), .TAG_W(TAG_W)) u_view (
    .base_i(base_q), .len_i(len_q), .q_pc_i(q_pc_i), .q_tag_i(q_tag_i),
    .q_exec_i(q_exec_i), .q_dir_i(q_dir_i), .req_pc_i(req_pc_i),
    .vld_o(vld), .pc_eq_o(pc_eq), .tag_o(r_tag), .exec_o(r_exec), .dir_o(r_dir)
  );

  logic             head_live;
  logic [OFF_W-1:0] hsel, after_head;
  logic [TAG_W-1:0] cur_tag, nxt_tag;
  logic             behind_any;

  assign head_live  = hoff_q < len_q;
  assign hsel       = (hoff_q < OFF_W'(DEPTH)) ? hoff_q : '0;
  assign after_head = hoff_q + OFF_W'(1);
  assign cur_tag    = r_tag[hsel*TAG_W +: TAG_W];

  always_comb begin
    behind_any = 1'b0;
    for (int o = 0; o < DEPTH; o++) begin
      tag_eq[o] = r_tag[o*TAG_W +: TAG_W] == cur_tag;
      tag_gt[o] = ser_gt(r_tag[o*TAG_W +: TAG_W], cur_tag);
      if ((OFF_W'(o) < hoff_q) && vld[o] && pc_eq[o] && tag_eq[o]) behind_any = 1'b1;
    end
  end

  logic             ahead_fnd, nxt_fnd, nm_fnd;
  logic [OFF_W-1:0] ahead_pos, nxt_pos, nm_pos;

  rrl_first #(.N(DEPTH), .W(OFF_W)) u_ahead (
    .vec_i(vld & pc_eq & tag_eq), .from_i(after_head),
    .found_o(ahead_fnd), .pos_o(ahead_pos)
  );
  rrl_first #(.N(DEPTH), .W(OFF_W)) u_next (
    .vec_i(vld & tag_gt), .from_i(after_head),
    .found_o(nxt_fnd), .pos_o(nxt_pos)
  );

  assign nxt_tag = r_tag[nxt_pos*TAG_W +: TAG_W];
  always_comb begin
    for (int o = 0; o < DEPTH; o++)
      nm_vec[o] = vld[o] && pc_eq[o] && (r_tag[o*TAG_W +: TAG_W] == nxt_tag);
  end

  rrl_first #(.N(DEPTH), .W(OFF_W)) u_nmatch (
    .vec_i(nm_vec), .from_i(nxt_pos), .found_o(nm_fnd), .pos_o(nm_pos)
  );

  // Classify the lookup.
  lk_kind_e         kind;
  logic [OFF_W-1:0] sel_pos;

  always_comb begin
    sel_pos = hsel;
    if (!head_live)            kind = LK_EMPTY;
    else if (pc_eq[hsel])      kind = LK_HIT_HEAD;
    else if (ahead_fnd) begin  kind = LK_HIT_AHEAD; sel_pos = ahead_pos; end
    else if (behind_any) begin
      if (!nxt_fnd)            kind = LK_MISS_END;
      else if (nm_fnd) begin   kind = LK_HIT_NEXT;  sel_pos = nm_pos; end
      else                     kind = LK_MISS_NEXT;
    end
    else                       kind = LK_MISS_INSERT;
  end

  // Next state.
  always_comb begin
    base_d     = base_q;
    len_d      = len_q;
    hoff_d     = hoff_q;
    rsp_hit_d  = 1'b0;
    rsp_exec_d = 1'b0;
    rsp_dir_d  = 1'b0;
    state_en   = load_i || req_valid_i;
    if (load_i) begin
      base_d = load_base_i;
      len_d  = load_len_i;
      hoff_d = '0;
    end else if (req_valid_i) begin
      unique case (kind)
        LK_HIT_HEAD, LK_HIT_AHEAD, LK_HIT_NEXT: begin
          rsp_hit_d  = 1'b1;
          rsp_exec_d = r_exec[sel_pos];
          rsp_dir_d  = r_dir[sel_pos];
          hoff_d     = sel_pos + OFF_W'(1);
        end
        LK_MISS_NEXT: hoff_d = nxt_pos;
        LK_MISS_END:  hoff_d = len_q;
        default:      hoff_d = hoff_q;
      endcase
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      hoff_q <= '0;
    end else if (state_en) begin
      base_q <= base_d;
      len_q  <= len_d;
      hoff_q <= hoff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_exec_o  <= 1'b0;
      rsp_dir_o   <= 1'b0;
    end else begin
      rsp_valid_o <= state_en;
      rsp_hit_o   <= rsp_hit_d;
      rsp_exec_o  <= rsp_exec_d;
      rsp_dir_o   <= rsp_dir_d;
    end
  end

  logic [OFF_W:0] hsum;
  assign hsum = {1'b0, OFF_W'(base_q)} + {1'b0, hoff_q};
  assign head_idx_o = (hsum >= (OFF_W+1)'(DEPTH)) ? IDX_W'(hsum - (OFF_W+1)'(DEPTH))
                                                  : IDX_W'(hsum);

  // Assertions.
  p_resp_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i || req_valid_i) |=> rsp_valid_o);
  p_load_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (load_len_i <= OFF_W'(DEPTH)));
  p_load_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (head_idx_o == $past(load_base_i)) && !rsp_hit_o);
  p_no_retreat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !load_i) |=> (hoff_q >= $past(hoff_q)));
  p_hit_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !load_i) |=> (!rsp_hit_o || (hoff_q > $past(hoff_q))));
  p_empty_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !load_i && (hoff_q >= len_q)) |=> (!rsp_hit_o && $stable(hoff_q)));
  p_head_in_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hoff_q <= len_q);
endmodule

// File: tb/rrl_replay_lookup_bench.sv
`timescale 1ns/1ps
module rrl_replay_lookup_bench;
  localparam int DEPTH = 16, PC_W = 16, TAG_W = 8;
  localparam int IDX_W = $clog2(DEPTH), OFF_W = $clog2(DEPTH + 1);
  localparam logic [PC_W-1:0] PA = 16'h0100, PB = 16'h0104, PC = 16'h0108,
                              PD = 16'h010C, PX = 16'h0200, PY = 16'h0204;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, req_valid = 1'b0;
  logic [IDX_W-1:0] load_base = '0;
  logic [OFF_W-1:0] load_len = '0;
  logic [PC_W-1:0] req_pc = '0;
  logic [DEPTH*PC_W-1:0] q_pc = '0;
  logic [DEPTH*TAG_W-1:0] q_tag = '0;
  logic [DEPTH-1:0] q_exec = '0, q_dir = '0;
  logic rsp_valid, rsp_hit, rsp_exec, rsp_dir;
  logic [IDX_W-1:0] head_idx;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rrl_replay_lookup #(.DEPTH(DEPTH), .PC_W(PC_W), .TAG_W(TAG_W)) u_rrl_replay_lookup (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_base_i(load_base), .load_len_i(load_len),
    .q_pc_i(q_pc), .q_tag_i(q_tag), .q_exec_i(q_exec), .q_dir_i(q_dir),
    .req_valid_i(req_valid), .req_pc_i(req_pc), .rsp_valid_o(rsp_valid),
    .rsp_hit_o(rsp_hit), .rsp_exec_o(rsp_exec), .rsp_dir_o(rsp_dir), .head_idx_o(head_idx));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(int i, logic [PC_W-1:0] pc, int tag, bit ex, bit dr);
    q_pc[i*PC_W +: PC_W] = pc;
    q_tag[i*TAG_W +: TAG_W] = TAG_W'(tag);
    q_exec[i] = ex;
    q_dir[i] = dr;
  endtask

  task automatic do_load(string req, int base, int len);
    @(negedge clk);
    load = 1'b1; load_base = IDX_W'(base); load_len = OFF_W'(len);
    @(negedge clk);
    load = 1'b0;
    chk(req, "load rsp_valid", int'(rsp_valid), 1);
    chk(req, "load head", int'(head_idx), base);
  endtask

  // Check response of the request presented one cycle earlier.
  task automatic judge(string req, bit hit, bit dr, bit ex, int head);
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "hit", int'(rsp_hit), int'(hit));
    if (hit) begin
      chk(req, "dir", int'(rsp_dir), int'(dr));
      chk(req, "exec", int'(rsp_exec), int'(ex));
    end
    chk(req, "head", int'(head_idx), head);
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc, bit hit, bit dr, bit ex, int head);
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    judge(req, hit, dr, ex, head);
  endtask

  task automatic clear_q();
    q_pc = '0; q_tag = '0; q_exec = '0; q_dir = '0;
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "head after reset", int'(head_idx), 0);
    put(0, PA, 0, 1, 1);
    look("R1", PA, 0, 0, 0, 0);
  endtask

  task automatic t_loop_window();
    clear_q();
    put(0, PA, 5, 1, 1); put(1, PB, 5, 1, 0); put(2, PC, 5, 0, 1);
    put(3, PA, 6, 1, 0); put(4, PB, 6, 0, 0); put(5, PC, 6, 1, 1);
    put(6, PA, 7, 1, 1); put(7, PB, 7, 1, 0); put(8, PC, 7, 0, 0);
    do_load("R2", 0, 9);
    // R4: back-to-back lookups A, B, C
    @(negedge clk); req_valid = 1'b1; req_pc = PA;
    @(negedge clk); judge("R4", 1, 1, 1, 1); req_pc = PB;
    @(negedge clk); judge("R4", 1, 0, 1, 2); req_pc = PC;
    @(negedge clk); judge("R4", 1, 1, 0, 3); req_valid = 1'b0;
    look("R5", PD, 0, 0, 0, 3);          // insertion: head unchanged
    look("R3", PA, 1, 0, 1, 4);          // direct hit at head
    look("R7", PA, 1, 1, 1, 7);          // match behind -> next iteration
    look("R6", PC, 1, 0, 0, 9);          // match ahead, skip B
    look("R10", PA, 0, 0, 0, 9);         // window exhausted
    look("R10", PC, 0, 0, 0, 9);
  endtask

  task automatic t_next_missing();
    clear_q();
    put(0, PA, 1, 1, 1); put(1, PB, 1, 1, 1); put(2, PC, 1, 1, 1);
    put(3, PB, 2, 0, 0); put(4, PC, 2, 1, 1); put(5, PD, 2, 1, 1);
    do_load("R8", 0, 6);
    look("R8", PA, 1, 1, 1, 1);
    look("R8", PA, 0, 0, 0, 3);          // new iteration lacks A
    look("R8", PB, 1, 0, 0, 4);
  endtask

  task automatic t_prefer_ahead();
    clear_q();
    put(0, PX, 0, 1, 1); put(1, PA, 0, 1, 1); put(2, PB, 0, 1, 1);
    put(3, PA, 0, 1, 0); put(4, PY, 1, 1, 1);
    do_load("R9", 0, 5);
    look("R9", PX, 1, 1, 1, 1);
    look("R9", PA, 1, 1, 1, 2);
    look("R9", PA, 1, 0, 1, 4);          // ahead match wins
  endtask

  task automatic t_tag_wrap();
    clear_q();
    put(0, PA, 255, 1, 1); put(1, PB, 255, 1, 1);
    put(2, PA, 0, 0, 1);   put(3, PB, 0, 1, 1);
    do_load("R11", 0, 4);
    look("R11", PA, 1, 1, 1, 1);
    look("R11", PA, 1, 1, 0, 3);         // tag 0 follows 255
  endtask

  task automatic t_circular_and_collide();
    clear_q();
    put(14, PA, 3, 1, 0); put(15, PB, 3, 1, 1);
    put(0, PC, 3, 1, 1);  put(1, PD, 3, 0, 0);
    do_load("R12", 14, 4);
    look("R12", PA, 1, 0, 1, 15);
    look("R12", PC, 1, 1, 1, 1);         // wraps to index 0, head index 1
    // R2: load and lookup in the same cycle
    @(negedge clk);
    load = 1'b1; load_base = IDX_W'(14); load_len = OFF_W'(4);
    req_valid = 1'b1; req_pc = PA;
    @(negedge clk);
    load = 1'b0; req_valid = 1'b0;
    judge("R2", 0, 0, 0, 14);
    look("R2", PA, 1, 0, 1, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loop_window();
    t_next_missing();
    t_prefer_ahead();
    t_tag_wrap();
    t_circular_and_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule